// File: doc/BRIEF.md
# Byte-Addressable CPU Register File

This block holds the programmer-visible 16-bit registers of a small 16-bit processor core. Eight general registers sit in one bank. Four of them are data registers, and each can be used as a full word or as its high or low byte on its own. The other four are pointer and index registers, which are always used as whole words. A second bank holds the four segment registers. A single status register stores only its implemented flag bits.

The general bank has two combinational read ports and one write port. Each port is addressed by a 3-bit register code plus a width bit. The segment bank has its own read and write ports, and the flag register has its own read and write pair. Every write lands on the rising clock edge. A read of a register during the cycle it is written shows the old contents. The instruction pointer, instruction decode and the ALU live outside this block.

Top module: `regfile16`

## Requirements
- R1: A synchronous active-high reset sets every general register, every segment register and every implemented flag bit to zero. After reset the flag port reads 16'h0002.
- R2: In word mode (width bit 0), codes 0 to 7 select, in that order, accumulator, count, data, base, stack pointer, base pointer, source index and destination index (slots 0 to 7). A word read returns all 16 bits of the selected slot.
- R3: A word write with the write enable high replaces all 16 bits of the selected slot at the next rising edge.
- R4: In byte mode (width bit 1), codes 0 to 3 select the low byte of slots 0 to 3 and codes 4 to 7 select the high byte of slots 0 to 3. A byte write changes only that byte and leaves the other byte of the same register unchanged.
- R5: A byte read places the selected byte on bits 7:0 of the read port and drives bits 15:8 to zero.
- R6: A byte write takes its value from bits 7:0 of the write data. Bits 15:8 of the write data have no effect.
- R7: The two general read ports decode their code and width bit independently and can return different registers in the same cycle.
- R8: A read of a register in the same cycle as a write to it returns the value held before the write. The new value is visible from the next cycle.
- R9: The segment bank holds four 16-bit registers, selected by a 2-bit index (0 code, 1 data, 2 stack, 3 extra). It has its own write port, and its writes never change the general registers.
- R10: A flag write stores only the nine bits in mask 16'h0FD5. Bit 1 always reads as 1, and bits 3, 5 and 15:12 always read as 0.
- R11: While a write enable is low, the register contents it controls do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_code | input | 3 | Read port A register code |
| rd_a_byte | input | 1 | Read port A width bit (1 = byte) |
| rd_a_data | output | 16 | Read port A data |
| rd_b_code | input | 3 | Read port B register code |
| rd_b_byte | input | 1 | Read port B width bit (1 = byte) |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_code | input | 3 | General write register code |
| wr_byte | input | 1 | General write width bit (1 = byte) |
| wr_data | input | 16 | General write data |
| seg_wr_en | input | 1 | Segment write enable |
| seg_wr_idx | input | 2 | Segment write index |
| seg_wr_data | input | 16 | Segment write data |
| seg_rd_idx | input | 2 | Segment read index |
| seg_rd_data | output | 16 | Segment read data |
| flg_wr_en | input | 1 | Flag write enable |
| flg_wr_data | input | 16 | Flag write data |
| flg_rd_data | output | 16 | Flag read data |

## Verification
All read ports are combinational. A read therefore reflects whatever the register holds in the current cycle, and every write shows up exactly one rising edge after it is presented. The bench drives all inputs one time unit after a rising edge. It samples reads within that same cycle, before the next edge.

A write is checked after the single edge that commits it. The same-cycle case is sampled twice: once before the committing edge, to see the old value, and once after it, to see the new value. Each sweep reads all sixteen code and width combinations on both ports and compares them with a word-and-byte-lane model kept in the bench.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned HALF_W = WORD_W / 2;
    localparam int unsigned N_GPR  = 8;
    localparam int unsigned N_SEG  = 4;
    localparam int unsigned CODE_W = $clog2(N_GPR);
    localparam int unsigned SEG_W  = $clog2(N_SEG);

    // Implemented flag positions and the values shown in the rest.
    localparam logic [WORD_W-1:0] FLAG_KEEP  = 16'h0FD5;
    localparam logic [WORD_W-1:0] FLAG_FIXED = 16'h0002;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        LANE_WORD = 2'd0,
        LANE_LO   = 2'd1,
        LANE_HI   = 2'd2
    } lane_e;

    typedef struct packed {
        logic [CODE_W-1:0] slot;
        lane_e             lane;
    } access_t;

    // Byte mode: the top code bit picks the high half and the low
    // bits pick one of the four splittable registers.
    function automatic access_t decode_access(input logic [CODE_W-1:0] code,
                                              input logic byte_mode);
        access_t a;
        if (byte_mode) begin
            a.slot = {1'b0, code[CODE_W-2:0]};
            a.lane = code[CODE_W-1] ? LANE_HI : LANE_LO;
        end else begin
            a.slot = code;
            a.lane = LANE_WORD;
        end
        return a;
    endfunction

    function automatic word_t pick_lane(input word_t w, input lane_e lane);
        case (lane)
            LANE_LO: pick_lane = {{HALF_W{1'b0}}, w[HALF_W-1:0]};
            LANE_HI: pick_lane = {{HALF_W{1'b0}}, w[WORD_W-1:HALF_W]};
            default: pick_lane = w;
        endcase
    endfunction

endpackage

// File: rtl/gpr_bank.sv
module gpr_bank
    import regfile_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  access_t                      wacc,
    input  word_t                        wdata,
    output logic [N_GPR-1:0][WORD_W-1:0] regs
);

    for (genvar r = 0; r < N_GPR; r++) begin : g_reg
        for (genvar h = 0; h < 2; h++) begin : g_half
            localparam lane_e MY_LANE = (h == 0) ? LANE_LO : LANE_HI;
            logic hit;
            assign hit = we && (wacc.slot == CODE_W'(r)) &&
                         (wacc.lane == LANE_WORD || wacc.lane == MY_LANE);

            always_ff @(posedge clk) begin
                if (rst)
                    regs[r][h*HALF_W +: HALF_W] <= '0;
                else if (hit)
                    regs[r][h*HALF_W +: HALF_W] <= (wacc.lane == LANE_WORD) ?
                        wdata[h*HALF_W +: HALF_W] : wdata[HALF_W-1:0];
            end
        end

        a_r3_word_write_lands: assert property (@(posedge clk) disable iff (rst)
            (we && wacc.lane == LANE_WORD && wacc.slot == CODE_W'(r))
            |=> regs[r] == $past(wdata));

        a_r4_low_write_keeps_high: assert property (@(posedge clk) disable iff (rst)
            (we && wacc.lane == LANE_LO && wacc.slot == CODE_W'(r))
            |=> regs[r][WORD_W-1:HALF_W] == $past(regs[r][WORD_W-1:HALF_W]));

        a_r6_high_write_from_low_data: assert property (@(posedge clk) disable iff (rst)
            (we && wacc.lane == LANE_HI && wacc.slot == CODE_W'(r))
            |=> regs[r][WORD_W-1:HALF_W] == $past(wdata[HALF_W-1:0]) &&
                regs[r][HALF_W-1:0] == $past(regs[r][HALF_W-1:0]));

        a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
            !we |=> $stable(regs[r]));
    end

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> regs == '0);

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import regfile_pkg::*;
(
    input  logic [N_GPR-1:0][WORD_W-1:0] regs,
    input  logic [CODE_W-1:0]            code,
    input  logic                         byte_mode,
    output word_t                        rdata
);

    access_t acc;

    always_comb begin
        acc   = decode_access(code, byte_mode);
        rdata = pick_lane(regs[acc.slot], acc.lane);
    end

endmodule

// File: rtl/seg_bank.sv
module seg_bank
    import regfile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEG_W-1:0] widx,
    input  word_t            wdata,
    input  logic [SEG_W-1:0] ridx,
    output word_t            rdata
);

    word_t seg_q [N_SEG];

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                seg_q[s] <= '0;
            else if (we && widx == SEG_W'(s))
                seg_q[s] <= wdata;
        end
    end

    assign rdata = seg_q[ridx];

    a_r9_seg_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> seg_q[$past(widx)] == $past(wdata));

endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import regfile_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  word_t wdata,
    output word_t rdata
);

    word_t flg_q;

    always_ff @(posedge clk) begin
        if (rst)
            flg_q <= FLAG_FIXED & ~FLAG_KEEP;
        else if (we)
            flg_q <= (wdata & FLAG_KEEP) | (FLAG_FIXED & ~FLAG_KEEP);
    end

    assign rdata = flg_q;

    a_r10_flag_masked_store: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata & FLAG_KEEP) == ($past(wdata) & FLAG_KEEP));

    a_r10_flag_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        !we |=> (rdata & ~FLAG_KEEP) == (FLAG_FIXED & ~FLAG_KEEP));

endmodule

// File: rtl/regfile16.sv
module regfile16
    import regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  rd_a_code,
    input  logic        rd_a_byte,
    output logic [15:0] rd_a_data,
    input  logic [2:0]  rd_b_code,
    input  logic        rd_b_byte,
    output logic [15:0] rd_b_data,
    input  logic        wr_en,
    input  logic [2:0]  wr_code,
    input  logic        wr_byte,
    input  logic [15:0] wr_data,
    input  logic        seg_wr_en,
    input  logic [1:0]  seg_wr_idx,
    input  logic [15:0] seg_wr_data,
    input  logic [1:0]  seg_rd_idx,
    output logic [15:0] seg_rd_data,
    input  logic        flg_wr_en,
    input  logic [15:0] flg_wr_data,
    output logic [15:0] flg_rd_data
);

    logic [N_GPR-1:0][WORD_W-1:0] gpr_q;
    access_t                      wacc;

    assign wacc = decode_access(wr_code, wr_byte);

    gpr_bank u_gpr (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .wacc  (wacc),
        .wdata (wr_data),
        .regs  (gpr_q)
    );

    logic [1:0][CODE_W-1:0] rp_code;
    logic [1:0]             rp_byte;
    word_t                  rp_data [2];

    assign rp_code = {rd_b_code, rd_a_code};
    assign rp_byte = {rd_b_byte, rd_a_byte};

    for (genvar p = 0; p < 2; p++) begin : g_rport
        gpr_read_port u_rp (
            .regs      (gpr_q),
            .code      (rp_code[p]),
            .byte_mode (rp_byte[p]),
            .rdata     (rp_data[p])
        );
    end

    assign rd_a_data = rp_data[0];
    assign rd_b_data = rp_data[1];

    seg_bank u_seg (
        .clk   (clk),
        .rst   (rst),
        .we    (seg_wr_en),
        .widx  (seg_wr_idx),
        .wdata (seg_wr_data),
        .ridx  (seg_rd_idx),
        .rdata (seg_rd_data)
    );

    flag_reg u_flg (
        .clk   (clk),
        .rst   (rst),
        .we    (flg_wr_en),
        .wdata (flg_wr_data),
        .rdata (flg_rd_data)
    );

    a_r9_seg_leaves_gpr: assert property (@(posedge clk) disable iff (rst)
        (seg_wr_en && !wr_en) |=> $stable(gpr_q));

endmodule

// File: tb/tb_regfile16.sv
module tb_regfile16;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  rd_a_code, rd_b_code, wr_code;
    logic        rd_a_byte, rd_b_byte, wr_byte, wr_en;
    logic [15:0] rd_a_data, rd_b_data, wr_data;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_idx, seg_rd_idx;
    logic [15:0] seg_wr_data, seg_rd_data;
    logic        flg_wr_en;
    logic [15:0] flg_wr_data, flg_rd_data;

    int total = 0;
    int bad   = 0;
    logic [15:0] m_gpr [8];
    logic [15:0] m_seg [4];

    always #(CLK_P/2) clk = ~clk;

    regfile16 dut (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [2:0] c, input logic b);
        if (!b) return m_gpr[c];
        return c[2] ? {8'h00, m_gpr[{1'b0, c[1:0]}][15:8]}
                    : {8'h00, m_gpr[{1'b0, c[1:0]}][7:0]};
    endfunction

    // Inputs change one unit after a rising edge; reads are combinational.
    task automatic gpr_write(input logic [2:0] c, input logic b, input logic [15:0] d);
        wr_en = 1'b1; wr_code = c; wr_byte = b; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (!b) m_gpr[c] = d;
        else if (c[2]) m_gpr[{1'b0, c[1:0]}][15:8] = d[7:0];
        else m_gpr[{1'b0, c[1:0]}][7:0] = d[7:0];
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 16; i++) begin
            rd_a_code = i[2:0];       rd_a_byte = i[3];
            rd_b_code = 3'(15 - i);   rd_b_byte = ~i[3];
            #1;
            chk({tag, " portA"}, rd_a_data, exp_rd(i[2:0], i[3]));
            chk({tag, " portB"}, rd_b_data, exp_rd(3'(15 - i), ~i[3]));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        for (int i = 0; i < 8; i++) m_gpr[i] = '0;
        for (int i = 0; i < 4; i++) m_seg[i] = '0;
    endtask

    initial begin
        rst = 1'b1; wr_en = 0; wr_code = 0; wr_byte = 0; wr_data = 0;
        rd_a_code = 0; rd_a_byte = 0; rd_b_code = 0; rd_b_byte = 0;
        seg_wr_en = 0; seg_wr_idx = 0; seg_wr_data = 0; seg_rd_idx = 0;
        flg_wr_en = 0; flg_wr_data = 0;
        do_reset();

        // R1: reset state
        sweep("R1 reset gpr");
        for (int s = 0; s < 4; s++) begin
            seg_rd_idx = 2'(s); #1;
            chk("R1 reset seg", seg_rd_data, 16'h0000);
        end
        chk("R1 reset flag", flg_rd_data, 16'h0002);

        // R2/R3/R5/R7: word writes to every slot, then cross-read
        for (int c = 0; c < 8; c++)
            gpr_write(3'(c), 1'b0, 16'(16'h1357 * (c + 1) + 16'h0A0B));
        sweep("R2 R3 R5 R7 word");

        // R4/R6: byte writes with junk in the upper data byte
        for (int c = 0; c < 8; c++)
            gpr_write(3'(c), 1'b1, {8'hEE, 8'(8'h40 + c * 8'h11)});
        sweep("R4 R6 byte");
        for (int c = 0; c < 8; c++)
            gpr_write(3'(c), 1'b1, {8'h5A, 8'(8'hC3 ^ c)});
        sweep("R4 R6 byte2");

        // R11: enable low, data presented
        wr_code = 3'd2; wr_byte = 1'b0; wr_data = 16'hFFFF; wr_en = 1'b0;
        @(posedge clk); #1;
        sweep("R11 no enable");

        // R8: same-cycle read of the register being written
        rd_a_code = 3'd5; rd_a_byte = 1'b0;
        rd_b_code = 3'd7; rd_b_byte = 1'b1;
        wr_en = 1'b1; wr_code = 3'd5; wr_byte = 1'b0; wr_data = 16'hBEEF;
        #1;
        chk("R8 old word", rd_a_data, m_gpr[5]);
        @(posedge clk); #1;
        wr_en = 1'b0; m_gpr[5] = 16'hBEEF;
        chk("R8 new word", rd_a_data, 16'hBEEF);
        wr_en = 1'b1; wr_code = 3'd7; wr_byte = 1'b1; wr_data = 16'h0077;
        #1;
        chk("R8 old byte", rd_b_data, {8'h00, m_gpr[3][15:8]});
        @(posedge clk); #1;
        wr_en = 1'b0; m_gpr[3][15:8] = 8'h77;
        chk("R8 new byte", rd_b_data, 16'h0077);

        // R9: segment bank
        for (int s = 0; s < 4; s++) begin
            seg_wr_en = 1'b1; seg_wr_idx = 2'(s);
            seg_wr_data = 16'(16'hA000 + s * 16'h0111);
            @(posedge clk); #1;
            m_seg[s] = seg_wr_data;
        end
        seg_wr_en = 1'b0;
        for (int s = 0; s < 4; s++) begin
            seg_rd_idx = 2'(s); #1;
            chk("R9 seg read", seg_rd_data, m_seg[s]);
        end
        sweep("R9 gpr untouched");

        // R10: flag masking
        begin
            logic [15:0] pats [4];
            pats[0] = 16'hFFFF; pats[1] = 16'h0000;
            pats[2] = 16'h1234; pats[3] = 16'hA5A5;
            for (int k = 0; k < 4; k++) begin
                flg_wr_en = 1'b1; flg_wr_data = pats[k];
                @(posedge clk); #1;
                flg_wr_en = 1'b0;
                chk("R10 flag", flg_rd_data, (pats[k] & 16'h0FD5) | 16'h0002);
            end
            flg_wr_data = 16'h0000;
            @(posedge clk); #1;
            chk("R10 R11 flag hold", flg_rd_data, (pats[3] & 16'h0FD5) | 16'h0002);
        end

        // R1: reset after use
        do_reset();
        sweep("R1 reset again");
        chk("R1 flag again", flg_rd_data, 16'h0002);
        seg_rd_idx = 2'd3; #1;
        chk("R1 seg again", seg_rd_data, 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule